// File: doc/BRIEF.md
# I/O-Port Bank Select Register

This block keeps a single "board active" flag for a memory board that shares its address range with other boards. Software switches boards in and out by writing a byte to an I/O port. The block watches the output cycles on the bus. When the port address of an output cycle equals the configured port number, the block copies one configured bit of the written byte into the flag. The flag then gates the board's memory decoder.

A power-on-clear input forces the flag to a configured default. The configured bit can also be marked as absent. The flag then stays at whatever power-on-clear gave it. With an active default, this makes a plain memory board that ignores all I/O.

Several instances can share one port number, each with its own data bit. A single write can then switch one bank off and another on in the same cycle.

Top module: `bank_select_reg`

## Requirements
- R1: While `poc_n` is low, `board_active` equals `cfg_default_on` (1 = active, 0 = inactive). The load is asynchronous and does not wait for a clock edge.
- R2: An output write (`io_out` high at a rising edge) whose `io_port` equals `cfg_port`, with `cfg_bit_valid` high, sets `board_active` to 1 after that edge if `io_data[cfg_bit]` is 1.
- R3: A write qualified as in R2 clears `board_active` to 0 if `io_data[cfg_bit]` is 0.
- R4: An output write whose `io_port` differs from `cfg_port` in any of its 8 bits leaves `board_active` unchanged. The port comparison also works at the boundary values 0x00 and 0xFF.
- R5: A cycle with `io_out` low leaves `board_active` unchanged, whatever `io_port` and `io_data` carry. Input cycles and memory cycles are of this kind.
- R6: With `cfg_bit_valid` low, no write changes `board_active`. An active default therefore stays active, and an inactive default stays inactive until the next power-on-clear.
- R7: Only the selected bit of `io_data` matters. With port 0x40 and bit 0, writing 0x71 activates the board and writing 0x72 deactivates it.
- R8: Two instances with the same `cfg_port` and different `cfg_bit` both respond to one write in the same cycle, each following its own bit.
- R9: When `poc_n` is low, it wins over an output write in the same cycle. `board_active` stays at `cfg_default_on`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| poc_n | input | 1 | Power-on-clear, active low, asynchronous |
| io_out | input | 1 | High for one clock during an output write cycle |
| io_port | input | 8 | I/O port address of the cycle |
| io_data | input | 8 | Data byte of the output write |
| cfg_port | input | 8 | Port number this board answers to |
| cfg_bit | input | 3 | Index of the data bit that carries the active state |
| cfg_bit_valid | input | 1 | 1 when a data bit is selected; 0 makes the block ignore I/O |
| cfg_default_on | input | 1 | State loaded by power-on-clear: 1 active, 0 inactive |
| board_active | output | 1 | Board enable for the memory decoder |

## Verification
Writes to the matching port are sent with bytes where the selected bit differs from its neighbours, such as 0x71 against 0x72 and 0x20 against 0xDF. This shows that the selected bit is the one being read. Writes to ports one bit away from the configured one, and configured ports at 0x00 and 0xFF, show that the comparison uses all 8 bits. Holding `io_out` low with a matching port, and clearing `cfg_bit_valid` under both defaults, separates the cycle qualifier from the port match. A second instance on the same port with a different bit shows two banks swapping on one write. Power-on-clear overlapping a write shows which of the two wins.

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              poc_n,
  input  logic              io_out,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [SEL_W-1:0]  cfg_bit,
  input  logic              cfg_bit_valid,
  input  logic              cfg_default_on,
  output logic              board_active
);

  logic hit;
  logic next_state;

  assign hit        = io_out && cfg_bit_valid && (io_port == cfg_port);
  assign next_state = io_data[cfg_bit];

  always_ff @(posedge clk or negedge poc_n) begin
    if (!poc_n)
      board_active <= cfg_default_on;
    else if (hit)
      board_active <= next_state;
  end

endmodule

// File: rtl/bank_select_chk.sv
module bank_select_chk #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              poc_n,
  input logic              io_out,
  input logic [PORT_W-1:0] io_port,
  input logic [DATA_W-1:0] io_data,
  input logic [PORT_W-1:0] cfg_port,
  input logic [SEL_W-1:0]  cfg_bit,
  input logic              cfg_bit_valid,
  input logic              cfg_default_on,
  input logic              board_active
);

  assert_reset_default_R1: assert property (@(posedge clk)
    !poc_n |=> board_active == $past(cfg_default_on));

  assert_load_bit_R2: assert property (@(posedge clk) disable iff (!poc_n)
    (io_out && cfg_bit_valid && io_port == cfg_port && io_data[cfg_bit]) |=> board_active);

  assert_clear_bit_R3: assert property (@(posedge clk) disable iff (!poc_n)
    (io_out && cfg_bit_valid && io_port == cfg_port && !io_data[cfg_bit]) |=> !board_active);

  assert_port_miss_R4: assert property (@(posedge clk) disable iff (!poc_n)
    (io_out && io_port != cfg_port) |=> $stable(board_active));

  assert_no_write_R5: assert property (@(posedge clk) disable iff (!poc_n)
    !io_out |=> $stable(board_active));

  assert_io_ignored_R6: assert property (@(posedge clk) disable iff (!poc_n)
    !cfg_bit_valid |=> $stable(board_active));

endmodule

bind bank_select_reg bank_select_chk #(
  .PORT_W(PORT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
) chk (
  .clk(clk), .poc_n(poc_n), .io_out(io_out), .io_port(io_port),
  .io_data(io_data), .cfg_port(cfg_port), .cfg_bit(cfg_bit),
  .cfg_bit_valid(cfg_bit_valid), .cfg_default_on(cfg_default_on),
  .board_active(board_active)
);

// File: tb/tb_bank_select_reg.sv
module tb_bank_select_reg;
  logic       clk = 1'b0;
  logic       poc_n = 1'b0;
  logic       io_out = 1'b0;
  logic [7:0] io_port = 8'h00;
  logic [7:0] io_data = 8'h00;
  logic [7:0] cfg_port = 8'h40;
  logic [2:0] cfg_bit_a = 3'd0;
  logic [2:0] cfg_bit_b = 3'd1;
  logic       cfg_bit_valid = 1'b1;
  logic       cfg_default_on = 1'b1;
  logic       act_a, act_b;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bank_select_reg dut (
    .clk(clk), .poc_n(poc_n), .io_out(io_out), .io_port(io_port),
    .io_data(io_data), .cfg_port(cfg_port), .cfg_bit(cfg_bit_a),
    .cfg_bit_valid(cfg_bit_valid), .cfg_default_on(cfg_default_on),
    .board_active(act_a)
  );

  bank_select_reg dut_b (
    .clk(clk), .poc_n(poc_n), .io_out(io_out), .io_port(io_port),
    .io_data(io_data), .cfg_port(cfg_port), .cfg_bit(cfg_bit_b),
    .cfg_bit_valid(cfg_bit_valid), .cfg_default_on(1'b0),
    .board_active(act_b)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: board_active=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic power_on(input logic dflt);
    @(negedge clk);
    cfg_default_on = dflt;
    poc_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    poc_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cycle(input logic strobe, input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    io_out  = strobe;
    io_port = port;
    io_data = data;
    @(negedge clk);
    io_out  = 1'b0;
  endtask

  task automatic t_reset_r1();
    power_on(1'b1);
    check("R1 default on", act_a, 1'b1);
    power_on(1'b0);
    check("R1 default off", act_a, 1'b0);
    cfg_default_on = 1'b1;
    #1 poc_n = 1'b0;
    #0.5;
    check("R1 asynchronous load", act_a, 1'b1);
    @(negedge clk);
    poc_n = 1'b1;
  endtask

  task automatic t_example_r7();
    cfg_port = 8'h40; cfg_bit_a = 3'd0; cfg_bit_valid = 1'b1;
    power_on(1'b1);
    cycle(1'b1, 8'h40, 8'h72);
    check("R7 0x72 deactivates", act_a, 1'b0);
    cycle(1'b1, 8'h40, 8'h71);
    check("R7 0x71 activates", act_a, 1'b1);
  endtask

  task automatic t_bit5_r2_r3();
    cfg_bit_a = 3'd5;
    power_on(1'b0);
    cycle(1'b1, 8'h40, 8'h20);
    check("R2 lone bit 5 set", act_a, 1'b1);
    cycle(1'b1, 8'h40, 8'hDF);
    check("R3 all but bit 5 set", act_a, 1'b0);
    cfg_bit_a = 3'd0;
  endtask

  task automatic t_port_miss_r4();
    power_on(1'b1);
    cycle(1'b1, 8'h41, 8'h00);
    check("R4 port 0x41 ignored", act_a, 1'b1);
    cycle(1'b1, 8'hC0, 8'h00);
    check("R4 port 0xC0 ignored", act_a, 1'b1);
    cfg_port = 8'hFF;
    cycle(1'b1, 8'hFE, 8'h00);
    check("R4 port 0xFE vs 0xFF ignored", act_a, 1'b1);
    cycle(1'b1, 8'hFF, 8'h00);
    check("R4 port 0xFF matches", act_a, 1'b0);
    cfg_port = 8'h00;
    cycle(1'b1, 8'h80, 8'h01);
    check("R4 port 0x80 vs 0x00 ignored", act_a, 1'b0);
    cycle(1'b1, 8'h00, 8'h01);
    check("R4 port 0x00 matches", act_a, 1'b1);
    cfg_port = 8'h40;
  endtask

  task automatic t_no_strobe_r5();
    power_on(1'b1);
    cycle(1'b0, 8'h40, 8'h00);
    check("R5 no output strobe", act_a, 1'b1);
  endtask

  task automatic t_ignore_io_r6();
    cfg_bit_valid = 1'b0;
    power_on(1'b1);
    cycle(1'b1, 8'h40, 8'h00);
    check("R6 active default held", act_a, 1'b1);
    power_on(1'b0);
    cycle(1'b1, 8'h40, 8'hFF);
    check("R6 inactive default held", act_a, 1'b0);
    cfg_bit_valid = 1'b1;
  endtask

  task automatic t_shared_port_r8();
    power_on(1'b1);
    check("R8 second bank starts off", act_b, 1'b0);
    cycle(1'b1, 8'h40, 8'h02);
    check("R8 bank A off", act_a, 1'b0);
    check("R8 bank B on", act_b, 1'b1);
    cycle(1'b1, 8'h40, 8'h01);
    check("R8 bank A on", act_a, 1'b1);
    check("R8 bank B off", act_b, 1'b0);
  endtask

  task automatic t_poc_priority_r9();
    power_on(1'b0);
    @(negedge clk);
    io_out = 1'b1; io_port = 8'h40; io_data = 8'hFF;
    poc_n = 1'b0;
    @(negedge clk);
    io_out = 1'b0;
    check("R9 clear beats write", act_a, 1'b0);
    poc_n = 1'b1;
    @(negedge clk);
    check("R9 still default after release", act_a, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset_r1();
        t_example_r7();
        t_bit5_r2_r3();
        t_port_miss_r4();
        t_no_strobe_r5();
        t_ignore_io_r6();
        t_shared_port_r8();
        t_poc_priority_r9();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule